// File: doc/BRIEF.md
# Dual-Port Memory with Collision Busy Arbitration

This block is a synchronous two-port memory. The two ports are called left and right. Each port has its own enable, address, write strobe and data, and it can read or write in any cycle. When both ports select the same word in the same cycle, an arbiter chooses one port to keep the word. The other port receives an active-low busy flag, and its write is dropped in that same cycle. The arbiter looks only at each port's enable and address. Whether the access is a read or a write plays no part in the decision.

A mode strap selects the role of the block. As the deciding slice (strap high), the block runs its own arbiter and drives the busy flags out. As a following slice (strap low), the block runs no arbitration. It takes a busy flag per port from outside and uses it only to block writes on that port. Several following slices can therefore share the decision of one deciding slice across a wide word, so no word is split between two different winners. A combined busy output, high when either port is flagged, can serve as an interrupt source.

Top module: `dpc_ram_top`

## Requirements
- R1: With the strap high, a port's `*_busy_n_out` goes low only when both ports are enabled at the same address. Reads count as accesses. At most one port is busy at a time, and with no such overlap both flags are high.
- R2: With the strap high, when an overlap starts and neither port (or both ports) was enabled at that address in the previous cycle, the left port wins and the right port is flagged busy.
- R3: With the strap high, if only one port was enabled at the shared address in the previous cycle, that port wins. The winner keeps its place while the overlap lasts, even if both ports move together to a new shared address. Busy clears in the first cycle without overlap.
- R4: With the strap high, a busy port's write leaves the memory unchanged. A busy port's read still returns the stored word.
- R5: With the strap high, the `*_busy_n_in` inputs have no effect on writes.
- R6: With the strap low, both `*_busy_n_out` stay high and `any_busy` stays low, whatever the addresses are.
- R7: With the strap low, a low `*_busy_n_in` blocks writes from that port only. A high `*_busy_n_in` leaves the port free.
- R8: With the strap low and both inhibit inputs high, if both ports write the same word in one cycle, the left port's data is stored.
- R9: `any_busy` is high exactly when at least one of `l_busy_n_out` and `r_busy_n_out` is low.
- R10: Read data appears one cycle after an enabled read. A word written by the other port in the same cycle reads back as its old content.
- R11: Synchronous reset clears both read data outputs to zero and clears the arbiter's memory of previous winners, so the first overlap after reset is treated as a tie.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| is_master | input | 1 | Strap: 1 runs the arbiter, 0 follows external busy inputs |
| l_en | input | 1 | Left port enable |
| l_we | input | 1 | Left port write strobe |
| l_addr | input | ADDR_W | Left port word address |
| l_wdata | input | DATA_W | Left port write data |
| l_rdata | output | DATA_W | Left port read data, one cycle latency |
| l_busy_n_in | input | 1 | Left write inhibit, active low, used when strap is low |
| l_busy_n_out | output | 1 | Left busy flag, active low, driven when strap is high |
| r_en | input | 1 | Right port enable |
| r_we | input | 1 | Right port write strobe |
| r_addr | input | ADDR_W | Right port word address |
| r_wdata | input | DATA_W | Right port write data |
| r_rdata | output | DATA_W | Right port read data, one cycle latency |
| r_busy_n_in | input | 1 | Right write inhibit, active low, used when strap is low |
| r_busy_n_out | output | 1 | Right busy flag, active low, driven when strap is high |
| any_busy | output | 1 | High when either port is flagged busy |

## Verification
The bench builds the block with ADDR_W = 3 and DATA_W = 8. Eight words let one vector table reach every stored word in the final readback, and let one run step through ties, first-arrival wins and overlaps that move to a new address. The byte-wide data gives each write a distinct value, so a dropped write, an inhibited write or the left-over-right ordering shows up in the readback.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    // Decide the keeper of a shared word: an ongoing owner stays,
    // otherwise the sole earlier arrival, otherwise the left port.
    function automatic owner_e pick_owner(owner_e cur, logic l_held, logic r_held);
        if (cur != OWN_NONE)
            return cur;
        if (r_held && !l_held)
            return OWN_RIGHT;
        return OWN_LEFT;
    endfunction

endpackage

// File: rtl/dpc_arbiter.sv
module dpc_arbiter
    import dpc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              master,
    input  logic              l_en,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              r_en,
    input  logic [ADDR_W-1:0] r_addr,
    output logic              l_busy,
    output logic              r_busy
);

    owner_e            owner_q;
    owner_e            owner_d;
    logic              pl_en, pr_en;
    logic [ADDR_W-1:0] pl_addr, pr_addr;
    logic              hit, l_held, r_held;

    always_comb begin
        hit     = l_en && r_en && (l_addr == r_addr);
        l_held  = pl_en && (pl_addr == l_addr);
        r_held  = pr_en && (pr_addr == r_addr);
        owner_d = pick_owner(owner_q, l_held, r_held);
        l_busy  = master && hit && (owner_d == OWN_RIGHT);
        r_busy  = master && hit && (owner_d == OWN_LEFT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            owner_q <= OWN_NONE;
            pl_en   <= 1'b0;
            pr_en   <= 1'b0;
            pl_addr <= '0;
            pr_addr <= '0;
        end else begin
            owner_q <= (master && hit) ? owner_d : OWN_NONE;
            pl_en   <= l_en;
            pr_en   <= r_en;
            pl_addr <= l_addr;
            pr_addr <= r_addr;
        end
    end

    // R1
    both_busy_chk: assert property (@(posedge clk) disable iff (rst)
        !(l_busy && r_busy));

    // R1
    busy_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (l_busy || r_busy) |-> (l_en && r_en && (l_addr == r_addr)));

    // R3
    owner_keep_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(r_busy) && master && l_en && r_en && (l_addr == r_addr))
        |-> r_busy);

endmodule

// File: rtl/dpc_mem.sv
module dpc_mem #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l_rd,
    input  logic              l_wr,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_rd,
    input  logic              r_wr,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    // Right first, left last: left wins a same-word double write.
    always_ff @(posedge clk) begin
        if (r_wr)
            store[r_addr] <= r_wdata;
        if (l_wr)
            store[l_addr] <= l_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            l_rdata <= '0;
            r_rdata <= '0;
        end else begin
            if (l_rd)
                l_rdata <= store[l_addr];
            if (r_rd)
                r_rdata <= store[r_addr];
        end
    end

endmodule

// File: rtl/dpc_ram_top.sv
module dpc_ram_top
    import dpc_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              is_master,
    input  logic              l_en,
    input  logic              l_we,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              l_busy_n_in,
    output logic              l_busy_n_out,
    input  logic              r_en,
    input  logic              r_we,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    input  logic              r_busy_n_in,
    output logic              r_busy_n_out,
    output logic              any_busy
);

    logic arb_l_busy, arb_r_busy;
    logic l_block, r_block;
    logic l_wr_go, r_wr_go;

    dpc_arbiter #(.ADDR_W(ADDR_W)) u_arb (
        .clk    (clk),
        .rst    (rst),
        .master (is_master),
        .l_en   (l_en),
        .l_addr (l_addr),
        .r_en   (r_en),
        .r_addr (r_addr),
        .l_busy (arb_l_busy),
        .r_busy (arb_r_busy)
    );

    always_comb begin
        l_block      = is_master ? arb_l_busy : !l_busy_n_in;
        r_block      = is_master ? arb_r_busy : !r_busy_n_in;
        l_wr_go      = l_en && l_we && !l_block;
        r_wr_go      = r_en && r_we && !r_block;
        l_busy_n_out = !(is_master && arb_l_busy);
        r_busy_n_out = !(is_master && arb_r_busy);
        any_busy     = !l_busy_n_out || !r_busy_n_out;
    end

    dpc_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .l_rd    (l_en),
        .l_wr    (l_wr_go),
        .l_addr  (l_addr),
        .l_wdata (l_wdata),
        .l_rdata (l_rdata),
        .r_rd    (r_en),
        .r_wr    (r_wr_go),
        .r_addr  (r_addr),
        .r_wdata (r_wdata),
        .r_rdata (r_rdata)
    );

    // R6
    slave_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !is_master |-> (l_busy_n_out && r_busy_n_out && !any_busy));

    // R4
    busy_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (is_master && !l_busy_n_out) |-> !l_wr_go);

    // R7
    inhibit_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (!is_master && !r_busy_n_in) |-> !r_wr_go);

endmodule

// File: tb/dpc_ram_top_tb.sv
module dpc_ram_top_tb;

    localparam int AW = 3;
    localparam int DW = 8;

    typedef struct packed {
        logic          m;
        logic          le;
        logic          lw;
        logic [AW-1:0] la;
        logic [DW-1:0] ld;
        logic          re;
        logic          rw;
        logic [AW-1:0] ra;
        logic [DW-1:0] rd;
        logic          lbi;
        logic          rbi;
        logic          elb;
        logic          erb;
        logic          eirq;
    } vec_t;

    localparam int NV = 13;
    // Fields: m, le, lw, la, ld, re, rw, ra, rd, lbi, rbi, exp l_busy_n, exp r_busy_n, exp any_busy
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b1, 1'b1, 3'd1, 8'h11, 1'b0, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // R1 R5
        '{1'b1, 1'b0, 1'b0, 3'd0, 8'h00, 1'b1, 1'b1, 3'd2, 8'h22, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}, // R1
        '{1'b1, 1'b1, 1'b1, 3'd3, 8'h33, 1'b1, 1'b1, 3'd3, 8'h44, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1}, // R2
        '{1'b1, 1'b0, 1'b0, 3'd0, 8'h00, 1'b1, 1'b1, 3'd4, 8'h55, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}, // R1
        '{1'b1, 1'b1, 1'b1, 3'd4, 8'h66, 1'b1, 1'b0, 3'd4, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1}, // R3
        '{1'b1, 1'b1, 1'b1, 3'd4, 8'h77, 1'b1, 1'b1, 3'd4, 8'h88, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1}, // R3
        '{1'b1, 1'b1, 1'b0, 3'd5, 8'h00, 1'b1, 1'b0, 3'd5, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1}, // R3
        '{1'b1, 1'b0, 1'b0, 3'd0, 8'h00, 1'b1, 1'b0, 3'd5, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}, // R3
        '{1'b1, 1'b1, 1'b0, 3'd6, 8'h00, 1'b1, 1'b0, 3'd6, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1}, // R2
        '{1'b0, 1'b1, 1'b1, 3'd1, 8'h99, 1'b0, 1'b0, 3'd0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R6 R7
        '{1'b0, 1'b1, 1'b1, 3'd2, 8'hAA, 1'b1, 1'b1, 3'd2, 8'hBB, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}, // R6 R7
        '{1'b0, 1'b1, 1'b1, 3'd7, 8'h01, 1'b1, 1'b1, 3'd7, 8'h02, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}, // R8
        '{1'b0, 1'b0, 1'b0, 3'd0, 8'h00, 1'b1, 1'b1, 3'd0, 8'h5A, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}  // R7
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          is_master;
    logic          l_en, l_we, r_en, r_we;
    logic [AW-1:0] l_addr, r_addr;
    logic [DW-1:0] l_wdata, r_wdata;
    logic [DW-1:0] l_rdata, r_rdata;
    logic          l_busy_n_in, r_busy_n_in;
    logic          l_busy_n_out, r_busy_n_out;
    logic          any_busy;

    int n_run = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    dpc_ram_top #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst), .is_master(is_master),
        .l_en(l_en), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata),
        .l_rdata(l_rdata), .l_busy_n_in(l_busy_n_in), .l_busy_n_out(l_busy_n_out),
        .r_en(r_en), .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata),
        .r_rdata(r_rdata), .r_busy_n_in(r_busy_n_in), .r_busy_n_out(r_busy_n_out),
        .any_busy(any_busy)
    );

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        is_master = 1'b1;
        l_en = 1'b0; l_we = 1'b0; l_addr = '0; l_wdata = '0;
        r_en = 1'b0; r_we = 1'b0; r_addr = '0; r_wdata = '0;
        l_busy_n_in = 1'b1; r_busy_n_in = 1'b1;
    endtask

    task automatic read_left(logic [AW-1:0] a, logic [DW-1:0] exp, string req);
        @(negedge clk);
        idle();
        l_en = 1'b1; l_addr = a;
        @(negedge clk);
        idle();
        check(req, l_rdata, exp);
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        idle();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        // R11 reset state
        check("R11 l_rdata", l_rdata, 8'h00);
        check("R11 r_rdata", r_rdata, 8'h00);
        check("R11 busy", {6'd0, l_busy_n_out, r_busy_n_out}, 8'h03);
        check("R11 any_busy", {7'd0, any_busy}, 8'h00);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            is_master = VEC[i].m;
            l_en = VEC[i].le; l_we = VEC[i].lw; l_addr = VEC[i].la; l_wdata = VEC[i].ld;
            r_en = VEC[i].re; r_we = VEC[i].rw; r_addr = VEC[i].ra; r_wdata = VEC[i].rd;
            l_busy_n_in = VEC[i].lbi; r_busy_n_in = VEC[i].rbi;
            #5;
            check($sformatf("R1 R2 R3 R6 l_busy_n vec%0d", i), {7'd0, l_busy_n_out}, {7'd0, VEC[i].elb});
            check($sformatf("R1 R2 R3 R6 r_busy_n vec%0d", i), {7'd0, r_busy_n_out}, {7'd0, VEC[i].erb});
            check($sformatf("R9 any_busy vec%0d", i), {7'd0, any_busy}, {7'd0, VEC[i].eirq});
        end
        @(negedge clk);
        idle();

        // Readback of the table's writes
        read_left(3'd0, 8'h5A, "R7 other port free");
        read_left(3'd1, 8'h11, "R5 R7 inhibited write kept old");
        read_left(3'd2, 8'hAA, "R7 right inhibited");
        read_left(3'd3, 8'h33, "R2 R4 tie loser dropped");
        read_left(3'd4, 8'h88, "R3 R4 first arrival kept");
        read_left(3'd7, 8'h01, "R8 left data stored");

        // R4 R10: busy right reads old word while left writes it
        @(negedge clk);
        idle();
        @(negedge clk);
        l_en = 1'b1; l_we = 1'b1; l_addr = 3'd3; l_wdata = 8'hCC;
        r_en = 1'b1; r_addr = 3'd3;
        #5;
        check("R2 r busy on read", {7'd0, r_busy_n_out}, 8'h00);
        @(negedge clk);
        idle();
        check("R4 R10 busy read old data", r_rdata, 8'h33);
        read_left(3'd3, 8'hCC, "R10 new data next read");

        // R11: reset clears previous winner
        @(negedge clk);
        idle();
        r_en = 1'b1; r_addr = 3'd2;
        @(negedge clk);
        l_en = 1'b1; l_addr = 3'd2;
        #5;
        check("R3 right arrived first", {6'd0, l_busy_n_out, r_busy_n_out}, 8'h01);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #5;
        check("R11 tie after reset", {6'd0, l_busy_n_out, r_busy_n_out}, 8'h02);
        check("R11 rdata cleared", l_rdata, 8'h00);
        @(negedge clk);
        idle();
        @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

endmodule